// File: doc/BRIEF.md
# Operand Bypass Select and Load-Use Stall Unit

This block resolves data hazards in a five-stage in-order pipeline. It has no storage and no clock. Every output is a function of the register indices and control flags that the pipeline registers present in the current cycle.

The bypass half serves each source operand of the instruction in the execute stage. It compares the operand's register index with the destination indices held in the two later stages. It then returns a 2-bit select for the operand multiplexer that lies outside the block. The nearer stage (execute/memory) has code 01 and the farther stage (memory/writeback) has code 10. Code 00 keeps the value read from the register file.

The stall half looks at the instruction in decode. If it needs a register that a load now in execute will write, the unit asserts a stall. The stall freezes the program counter and the fetch/decode register and turns the next decode/execute entry into a bubble.

Top module: `hz_bypass_stall_unit`

## Requirements
- R1: An operand's select is 01 when its index is nonzero, equals `mem_dst_idx`, and `mem_dst_we` is 1.
- R2: When R1 does not apply, the select is 10 if the index is nonzero, equals `wb_dst_idx`, and `wb_dst_we` is 1.
- R3: When both stages hold the operand's register with write enabled, the select is 01 (nearer stage wins).
- R4: The select is 00 when neither stage supplies the operand, and it never takes the value 11.
- R5: Each operand's select depends only on that operand's own index. Operand 0 is rs1 and operand 1 is rs2.
- R6: Register index 0 never produces a nonzero select, whatever the stage destinations and write flags are.
- R7: `stall` is 1 exactly when `exe_mem_rd` is 1 and `exe_dst_idx` equals either decode source index. This includes index 0.
- R8: While `stall` is 1, `pc_we` and `ifid_we` are 0 and `bubble_sel` is 1.
- R9: While `stall` is 0, `pc_we` and `ifid_we` are 1 and `bubble_sel` is 0.
- R10: The stall outputs and the bypass selects are computed in the same cycle and do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_idx | input | NUM_SRC x IDX_W | Source register indices of the instruction in execute |
| mem_dst_idx | input | IDX_W | Destination index held in the execute/memory register |
| mem_dst_we | input | 1 | Register-write flag of the execute/memory instruction |
| wb_dst_idx | input | IDX_W | Destination index held in the memory/writeback register |
| wb_dst_we | input | 1 | Register-write flag of the memory/writeback instruction |
| dec_src_idx | input | NUM_SRC x IDX_W | Source indices of the instruction in decode |
| exe_dst_idx | input | IDX_W | Destination index of the instruction in execute |
| exe_mem_rd | input | 1 | High when the instruction in execute is a load |
| fwd_sel | output | NUM_SRC x 2 | Bypass select for each operand (00 file, 01 near, 10 far) |
| stall | output | 1 | Load-use hazard detected |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble_sel | output | 1 | Forces zeros into the decode/execute control fields |

## Verification
The hardest case to reach is a collision. Both later stages name the same register, with either write flag disabled, while register 0 and the load comparison take part in the same vector. Random index choice almost never produces such a collision. A vector table therefore builds each collision on purpose: both stages matching, a disabled nearer stage exposing the farther one, and a load into register 0. A loop then drives indices drawn from a narrow 3-bit range, so that matches occur often, and compares every output with a model held in the bench.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      FWD_NONE = 2'b00,
      FWD_NEAR = 2'b01,
      FWD_FAR  = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
   import hz_pkg::*;
#(
   parameter int IDX_W         = 5,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input  logic [IDX_W-1:0] src_idx,
   input  logic [IDX_W-1:0] near_idx,
   input  logic             near_we,
   input  logic [IDX_W-1:0] far_idx,
   input  logic             far_we,
   output fwd_sel_e         sel
);
   logic src_live;
   logic near_hit;
   logic far_hit;

   generate
      if (ZERO_IS_CONST) begin : g_zero_const
         assign src_live = |src_idx;
      end else begin : g_zero_plain
         assign src_live = 1'b1;
      end
   endgenerate

   assign near_hit = src_live && near_we && (src_idx == near_idx);
   assign far_hit  = src_live && far_we  && (src_idx == far_idx);

   always_comb begin
      if (near_hit)     sel = FWD_NEAR;
      else if (far_hit) sel = FWD_FAR;
      else              sel = FWD_NONE;
   end

   always_comb begin
      if (!$isunknown({src_idx, near_idx, near_we, far_idx, far_we})) begin
         // R4
         sel_legal_chk: assert (sel != 2'b11);
         // R2
         far_needs_we_chk: assert (sel != FWD_FAR || far_we);
      end
   end
endmodule

// File: rtl/hz_load_stall.sv
module hz_load_stall #(
   parameter int IDX_W      = 5,
   parameter int NUM_SRC    = 2,
   parameter bit SKIP_ZERO  = 1'b0
) (
   input  logic [NUM_SRC-1:0][IDX_W-1:0] dec_src,
   input  logic [IDX_W-1:0]              ld_dst,
   input  logic                          ld_active,
   output logic                          stall,
   output logic                          pc_we,
   output logic                          ifid_we,
   output logic                          bubble
);
   logic [NUM_SRC-1:0] src_hit;
   logic               dst_live;

   generate
      if (SKIP_ZERO) begin : g_skip_zero
         assign dst_live = |ld_dst;
      end else begin : g_any_dst
         assign dst_live = 1'b1;
      end
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
         assign src_hit[s] = (dec_src[s] == ld_dst);
      end
   endgenerate

   always_comb begin
      stall   = ld_active && dst_live && (|src_hit);
      pc_we   = ~stall;
      ifid_we = ~stall;
      bubble  = stall;
   end
endmodule

// File: rtl/hz_bypass_stall_unit.sv
module hz_bypass_stall_unit
   import hz_pkg::*;
#(
   parameter int IDX_W         = 5,
   parameter int NUM_SRC       = 2,
   parameter bit ZERO_IS_CONST = 1'b1,
   parameter bit STALL_SKIP_ZERO = 1'b0
) (
   input  logic [NUM_SRC-1:0][IDX_W-1:0] ex_src_idx,
   input  logic [IDX_W-1:0]              mem_dst_idx,
   input  logic                          mem_dst_we,
   input  logic [IDX_W-1:0]              wb_dst_idx,
   input  logic                          wb_dst_we,
   input  logic [NUM_SRC-1:0][IDX_W-1:0] dec_src_idx,
   input  logic [IDX_W-1:0]              exe_dst_idx,
   input  logic                          exe_mem_rd,
   output logic [NUM_SRC-1:0][1:0]       fwd_sel,
   output logic                          stall,
   output logic                          pc_we,
   output logic                          ifid_we,
   output logic                          bubble_sel
);
   localparam int NUM_REGS = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("IDX_W out of range");
      end
      if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_src
         $error("NUM_SRC out of range");
      end
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("register space too small");
      end
   endgenerate

   fwd_sel_e sel_q [NUM_SRC];

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
         hz_operand_fwd #(
            .IDX_W         (IDX_W),
            .ZERO_IS_CONST (ZERO_IS_CONST)
         ) u_fwd (
            .src_idx  (ex_src_idx[i]),
            .near_idx (mem_dst_idx),
            .near_we  (mem_dst_we),
            .far_idx  (wb_dst_idx),
            .far_we   (wb_dst_we),
            .sel      (sel_q[i])
         );
         assign fwd_sel[i] = sel_q[i];
      end
   endgenerate

   hz_load_stall #(
      .IDX_W     (IDX_W),
      .NUM_SRC   (NUM_SRC),
      .SKIP_ZERO (STALL_SKIP_ZERO)
   ) u_stall (
      .dec_src   (dec_src_idx),
      .ld_dst    (exe_dst_idx),
      .ld_active (exe_mem_rd),
      .stall     (stall),
      .pc_we     (pc_we),
      .ifid_we   (ifid_we),
      .bubble    (bubble_sel)
   );

   always_comb begin
      if (!$isunknown({ex_src_idx, mem_dst_idx, mem_dst_we, wb_dst_idx, wb_dst_we,
                       dec_src_idx, exe_dst_idx, exe_mem_rd})) begin
         // R7
         stall_needs_load_chk: assert (!stall || exe_mem_rd);
         // R8
         stall_freezes_chk: assert (!stall || (!pc_we && !ifid_we && bubble_sel));
         // R9
         run_enables_chk: assert (stall || (pc_we && ifid_we && !bubble_sel));
         for (int i = 0; i < NUM_SRC; i++) begin
            // R6
            zero_src_chk: assert (!ZERO_IS_CONST || ex_src_idx[i] != '0 || fwd_sel[i] == FWD_NONE);
            // R1
            near_needs_we_chk: assert (fwd_sel[i] != FWD_NEAR || mem_dst_we);
         end
      end
   end
endmodule

// File: tb/tb_hz_bypass_stall_unit.sv
module tb_hz_bypass_stall_unit;
   localparam int W = 5;
   localparam int NV = 10;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [1:0][W-1:0] ex_src_idx, dec_src_idx;
   logic [W-1:0] mem_dst_idx, wb_dst_idx, exe_dst_idx;
   logic mem_dst_we, wb_dst_we, exe_mem_rd;
   logic [1:0][1:0] fwd_sel;
   logic stall, pc_we, ifid_we, bubble_sel;

   int checks = 0;
   int fails = 0;

   hz_bypass_stall_unit dut (
      .ex_src_idx(ex_src_idx), .mem_dst_idx(mem_dst_idx), .mem_dst_we(mem_dst_we),
      .wb_dst_idx(wb_dst_idx), .wb_dst_we(wb_dst_we), .dec_src_idx(dec_src_idx),
      .exe_dst_idx(exe_dst_idx), .exe_mem_rd(exe_mem_rd), .fwd_sel(fwd_sel),
      .stall(stall), .pc_we(pc_we), .ifid_we(ifid_we), .bubble_sel(bubble_sel)
   );

   typedef struct packed {
      logic [W-1:0] a; logic [W-1:0] b;
      logic [W-1:0] nr; logic nw;
      logic [W-1:0] fr; logic fw;
      logic [W-1:0] da; logic [W-1:0] db;
      logic [W-1:0] lr; logic lm;
      logic [1:0] xa; logic [1:0] xb; logic xs;
   } vec_t;

   localparam vec_t VEC [NV] = '{
      '{a:0,  b:0,  nr:0,  nw:0, fr:0,  fw:0, da:0,  db:0,  lr:0,  lm:0, xa:0, xb:0, xs:0},
      '{a:3,  b:4,  nr:3,  nw:1, fr:9,  fw:1, da:1,  db:2,  lr:7,  lm:0, xa:1, xb:0, xs:0},
      '{a:5,  b:6,  nr:1,  nw:1, fr:6,  fw:1, da:1,  db:2,  lr:1,  lm:1, xa:0, xb:2, xs:1},
      '{a:8,  b:8,  nr:8,  nw:1, fr:8,  fw:1, da:5,  db:4,  lr:4,  lm:1, xa:1, xb:1, xs:1},
      '{a:8,  b:2,  nr:8,  nw:0, fr:8,  fw:1, da:3,  db:3,  lr:3,  lm:0, xa:2, xb:0, xs:0},
      '{a:0,  b:0,  nr:0,  nw:1, fr:0,  fw:1, da:0,  db:9,  lr:0,  lm:1, xa:0, xb:0, xs:1},
      '{a:31, b:31, nr:30, nw:1, fr:31, fw:0, da:31, db:30, lr:31, lm:1, xa:0, xb:0, xs:1},
      '{a:12, b:13, nr:13, nw:1, fr:12, fw:1, da:6,  db:7,  lr:8,  lm:1, xa:2, xb:1, xs:0},
      '{a:17, b:0,  nr:17, nw:1, fr:0,  fw:1, da:20, db:21, lr:21, lm:1, xa:1, xb:0, xs:1},
      '{a:2,  b:2,  nr:5,  nw:1, fr:5,  fw:1, da:5,  db:5,  lr:5,  lm:0, xa:0, xb:0, xs:0}
   };

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [1:0] mdl_sel(logic [W-1:0] s, logic [W-1:0] nr, logic nw,
                                          logic [W-1:0] fr, logic fw);
      if (s != 0 && nw && s == nr) return 2'b01;
      if (s != 0 && fw && s == fr) return 2'b10;
      return 2'b00;
   endfunction

   task automatic apply(input vec_t v);
      @(posedge clk);
      ex_src_idx[0] = v.a;  ex_src_idx[1] = v.b;
      mem_dst_idx = v.nr;   mem_dst_we = v.nw;
      wb_dst_idx = v.fr;    wb_dst_we = v.fw;
      dec_src_idx[0] = v.da; dec_src_idx[1] = v.db;
      exe_dst_idx = v.lr;   exe_mem_rd = v.lm;
      @(negedge clk);
   endtask

   task automatic check_all(input vec_t v, input string tag);
      // R1 R2 R3 R4 R5 R6 operand selects
      chk({tag, " R1 R2 R3 R4 R6 opA"}, fwd_sel[0], v.xa);
      chk({tag, " R5 opB"}, fwd_sel[1], v.xb);
      // R7 R10 stall
      chk({tag, " R7 R10 stall"}, {1'b0, stall}, {1'b0, v.xs});
      // R8 R9 enables
      chk({tag, " R8 R9 pc_we"}, {1'b0, pc_we}, {1'b0, ~v.xs});
      chk({tag, " R8 R9 ifid_we"}, {1'b0, ifid_we}, {1'b0, ~v.xs});
      chk({tag, " R8 R9 bubble"}, {1'b0, bubble_sel}, {1'b0, v.xs});
   endtask

   initial begin
      #200000;
      fails++; checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      ex_src_idx = '0; dec_src_idx = '0; mem_dst_idx = '0; wb_dst_idx = '0;
      exe_dst_idx = '0; mem_dst_we = 0; wb_dst_we = 0; exe_mem_rd = 0;
      @(negedge clk);
      // idle state: R9 enables high, R4 no bypass
      chk("R9 idle pc_we", {1'b0, pc_we}, 2'b01);
      chk("R4 idle selA", fwd_sel[0], 2'b00);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         check_all(VEC[i], $sformatf("vec%0d", i));
      end

      // R6: register 0 with both stages writing register 0
      begin
         vec_t z;
         z = '{a:0, b:0, nr:0, nw:1, fr:0, fw:1, da:1, db:2, lr:3, lm:1, xa:0, xb:0, xs:0};
         apply(z);
         check_all(z, "zero R6");
      end

      // random sweep over a narrow index range so matches are common
      begin
         logic [31:0] lf = 32'h1ACE_B00C;
         for (int n = 0; n < 400; n++) begin
            vec_t r;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            r.a = {2'b0, lf[2:0]};   r.b = {2'b0, lf[5:3]};
            r.nr = {2'b0, lf[8:6]};  r.nw = lf[9];
            r.fr = {2'b0, lf[12:10]}; r.fw = lf[13];
            r.da = {2'b0, lf[16:14]}; r.db = {2'b0, lf[19:17]};
            r.lr = {2'b0, lf[22:20]}; r.lm = lf[23];
            r.xa = mdl_sel(r.a, r.nr, r.nw, r.fr, r.fw);
            r.xb = mdl_sel(r.b, r.nr, r.nw, r.fr, r.fw);
            r.xs = r.lm && (r.lr == r.da || r.lr == r.db);
            apply(r);
            check_all(r, "sweep");
         end
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule